// File: doc/BRIEF.md
# Bus Transaction Trace Recorder

This block watches the bus of an 8-bit processor with a 16-bit address bus and keeps a rolling history of its bus transactions. For every valid bus cycle whose type is enabled, it writes the address, the data, the four control bits and the cycle type into a circular buffer of `DEPTH` entries (256 by default). When the buffer is full, each new entry overwrites the oldest one.

A trigger comparator checks each valid cycle against a programmable value and mask for the address, the data and the control bits. When the trigger is armed and a cycle matches, recording freezes. The block then does one of two things. It can raise a halt request, so that the processor stops at a transaction boundary. Or it can emit a single-cycle sync pulse and leave the processor running.

The history is read back through an index port. Index 0 is the newest entry. A host that wants the last n entries, oldest first, reads indices n-1 down to 0.

Top module: `trace_recorder`

## Requirements
- R1: A stored entry holds the bus address, the data, the 4 control bits and the 2-bit cycle type of the transaction that produced it.
- R2: Cycle types are encoded 0 = memory read, 1 = memory write, 2 = I/O read, 3 = I/O write. A valid cycle is stored only when bit `bus_type` of `type_enable` is 1. A cycle of a disabled type changes neither `fill_count` nor the buffer contents.
- R3: The buffer is circular. After more than `DEPTH` stores, index k returns the k-th newest entry, and the oldest entries have been overwritten.
- R4: `fill_count` counts stored entries and saturates at `DEPTH`. A read whose index is not below `fill_count` returns `rd_hit` = 0.
- R5: A cycle matches when `bus_valid` is 1 and the address, data and control each equal their trigger value in every bit whose mask bit is 1. Mask bits that are 0 are don't-care. A match has no effect while `trig_arm` is 0.
- R6: In halt mode (`trig_halt_en` = 1), `halt_req` rises on the edge that takes in the triggering cycle. It stays high until `trig_arm` is brought low.
- R7: In sync mode (`trig_halt_en` = 0), a trigger gives `sync_pulse` high for exactly one cycle, and `halt_req` stays low.
- R8: The trigger sets `frozen`. The triggering cycle itself is still stored if its type is enabled. While frozen, no later cycle is stored and no further trigger occurs. Bringing `trig_arm` low clears `frozen` and lets recording resume.
- R9: A read request with index i gives, one cycle later, `rd_valid` = 1 and the entry written i stores before the newest. The newest entry is index 0.
- R10: After reset, `fill_count` is 0 and `frozen`, `halt_req`, `sync_pulse` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | A bus transaction is present this cycle |
| bus_type | input | 2 | Cycle type (R2 encoding) |
| bus_addr | input | 16 | Address bus |
| bus_data | input | 8 | Data bus |
| bus_ctrl | input | 4 | Control bus bits |
| type_enable | input | 4 | Per-type store enable, bit index = cycle type |
| trig_arm | input | 1 | Arms the trigger; low clears freeze and halt |
| trig_halt_en | input | 1 | 1: halt request on trigger, 0: sync pulse |
| trig_addr_val | input | 16 | Address compare value |
| trig_addr_mask | input | 16 | Address compare mask (1 = compare) |
| trig_data_val | input | 8 | Data compare value |
| trig_data_mask | input | 8 | Data compare mask |
| trig_ctrl_val | input | 4 | Control compare value |
| trig_ctrl_mask | input | 4 | Control compare mask |
| rd_req | input | 1 | Read request |
| rd_index | input | 8 | Read index counted back from newest |
| fill_count | output | 9 | Number of valid entries, saturating |
| frozen | output | 1 | Recording stopped by the trigger |
| halt_req | output | 1 | Halt request to the processor |
| sync_pulse | output | 1 | One-cycle trigger pulse |
| rd_valid | output | 1 | Read result present |
| rd_hit | output | 1 | Requested index holds a written entry |
| rd_addr | output | 16 | Read entry address |
| rd_data | output | 8 | Read entry data |
| rd_ctrl | output | 4 | Read entry control bits |
| rd_type | output | 2 | Read entry cycle type |

## Verification
A wrong write pointer shows up on the very next read of index 0 as a stale or misplaced entry. A wrong fill counter shows up in `fill_count` and in `rd_hit` for the highest indices. Both are visible one cycle after the faulty store. A freeze or trigger fault shows at the ports on the edge after the triggering cycle, either as a missing or lingering `halt_req` or `sync_pulse`, or as a later cycle that appears at index 0 when it should not. Reading back after a wrap of more than `DEPTH` stores shows whether the pointer arithmetic keeps the right ordering.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    CYC_MEM_RD = 2'd0,
    CYC_MEM_WR = 2'd1,
    CYC_IO_RD  = 2'd2,
    CYC_IO_WR  = 2'd3
  } cyc_type_e;

  // Equality on the bits selected by mask.
  function automatic logic masked_eq(input logic [31:0] a,
                                     input logic [31:0] b,
                                     input logic [31:0] m);
    return ((a ^ b) & m) == 32'd0;
  endfunction

  // Slot holding the entry idx steps back from the newest.
  function automatic int unsigned slot_back(input int unsigned wp,
                                            input int unsigned idx,
                                            input int unsigned depth);
    return (wp + depth + depth - 1 - idx) % depth;
  endfunction

  // Saturating fill count update.
  function automatic int unsigned fill_next(input int unsigned fill,
                                            input logic inc,
                                            input int unsigned depth);
    if (inc && fill < depth) return fill + 1;
    return fill;
  endfunction

endpackage

// File: rtl/trace_match.sv
module trace_match #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] ctrl,
  input  logic [AW-1:0] addr_val,
  input  logic [AW-1:0] addr_mask,
  input  logic [DW-1:0] data_val,
  input  logic [DW-1:0] data_mask,
  input  logic [CW-1:0] ctrl_val,
  input  logic [CW-1:0] ctrl_mask,
  output logic          hit
);
  import trace_pkg::*;

  logic addr_ok, data_ok, ctrl_ok;

  always_comb begin
    addr_ok = masked_eq(32'(addr), 32'(addr_val), 32'(addr_mask));
    data_ok = masked_eq(32'(data), 32'(data_val), 32'(data_mask));
    ctrl_ok = masked_eq(32'(ctrl), 32'(ctrl_val), 32'(ctrl_mask));
    hit     = addr_ok && data_ok && ctrl_ok;
  end

endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int EW    = 30,
  parameter int DEPTH = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [EW-1:0]    wr_entry,
  input  logic             rd_req,
  input  logic [PTR_W-1:0] rd_index,
  output logic [CNT_W-1:0] fill,
  output logic             rd_valid,
  output logic             rd_hit,
  output logic [EW-1:0]    rd_entry
);
  import trace_pkg::*;

  logic [EW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_slot;
  logic             idx_in_range;

  always_comb begin
    rd_slot      = PTR_W'(slot_back(int'(unsigned'(wr_ptr)), int'(unsigned'(rd_index)), DEPTH));
    idx_in_range = int'(unsigned'(rd_index)) < int'(unsigned'(fill));
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (wr_en) wr_ptr <= PTR_W'((int'(unsigned'(wr_ptr)) + 1) % DEPTH);
      fill <= CNT_W'(fill_next(int'(unsigned'(fill)), wr_en, DEPTH));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_hit   <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      rd_hit   <= rd_req && idx_in_range;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_req) rd_entry <= mem[rd_slot];
  end

endmodule

// File: rtl/trace_ctl.sv
module trace_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic halt_en,
  input  logic cyc_match,
  output logic trig_fire,
  output logic frozen,
  output logic halt_req,
  output logic sync_pulse
);

  assign trig_fire = arm && cyc_match && !frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen     <= 1'b0;
      halt_req   <= 1'b0;
      sync_pulse <= 1'b0;
    end else begin
      sync_pulse <= trig_fire && !halt_en;
      if (!arm) begin
        frozen   <= 1'b0;
        halt_req <= 1'b0;
      end else if (trig_fire) begin
        frozen <= 1'b1;
        if (halt_en) halt_req <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/trace_recorder.sv
module trace_recorder #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CW    = 4,
  parameter int DEPTH = 256,
  localparam int TW    = 2,
  localparam int NTYPE = 1 << TW,
  localparam int EW    = AW + DW + CW + TW,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic [TW-1:0]    bus_type,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic [CW-1:0]    bus_ctrl,
  input  logic [NTYPE-1:0] type_enable,
  input  logic             trig_arm,
  input  logic             trig_halt_en,
  input  logic [AW-1:0]    trig_addr_val,
  input  logic [AW-1:0]    trig_addr_mask,
  input  logic [DW-1:0]    trig_data_val,
  input  logic [DW-1:0]    trig_data_mask,
  input  logic [CW-1:0]    trig_ctrl_val,
  input  logic [CW-1:0]    trig_ctrl_mask,
  input  logic             rd_req,
  input  logic [PTR_W-1:0] rd_index,
  output logic [CNT_W-1:0] fill_count,
  output logic             frozen,
  output logic             halt_req,
  output logic             sync_pulse,
  output logic             rd_valid,
  output logic             rd_hit,
  output logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [CW-1:0]    rd_ctrl,
  output logic [TW-1:0]    rd_type
);

  // Named internal events
  logic          store_fire;
  logic          match_hit;
  logic          cyc_match;
  logic          trig_fire;
  logic [EW-1:0] wr_entry;
  logic [EW-1:0] rd_entry;

  assign cyc_match  = bus_valid && match_hit;
  assign store_fire = bus_valid && type_enable[bus_type] && !frozen;
  assign wr_entry   = {bus_type, bus_ctrl, bus_data, bus_addr};
  assign {rd_type, rd_ctrl, rd_data, rd_addr} = rd_entry;

  trace_match #(.AW(AW), .DW(DW), .CW(CW)) match_i (
    .addr(bus_addr), .data(bus_data), .ctrl(bus_ctrl),
    .addr_val(trig_addr_val), .addr_mask(trig_addr_mask),
    .data_val(trig_data_val), .data_mask(trig_data_mask),
    .ctrl_val(trig_ctrl_val), .ctrl_mask(trig_ctrl_mask),
    .hit(match_hit)
  );

  trace_ctl ctl_i (
    .clk(clk), .rst_n(rst_n), .arm(trig_arm), .halt_en(trig_halt_en),
    .cyc_match(cyc_match), .trig_fire(trig_fire), .frozen(frozen),
    .halt_req(halt_req), .sync_pulse(sync_pulse)
  );

  trace_store #(.EW(EW), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(store_fire), .wr_entry(wr_entry),
    .rd_req(rd_req), .rd_index(rd_index), .fill(fill_count),
    .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_entry(rd_entry)
  );

endmodule

// File: rtl/trace_recorder_chk.sv
module trace_recorder_chk #(
  parameter int DEPTH = 256,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             store_fire,
  input logic             trig_fire,
  input logic             trig_arm,
  input logic             trig_halt_en,
  input logic             frozen,
  input logic             halt_req,
  input logic             sync_pulse,
  input logic [CNT_W-1:0] fill_count,
  input logic             rd_req,
  input logic             rd_valid
);

  // R4
  fill_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(unsigned'(fill_count)) <= DEPTH);

  // R4
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire && (int'(unsigned'(fill_count)) < DEPTH)
      |=> fill_count == CNT_W'($past(fill_count) + 1'b1));

  // R8
  freeze_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> frozen);

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && trig_arm |=> frozen && $stable(fill_count));

  // R6
  halt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire && trig_halt_en |=> halt_req);

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && trig_arm |=> halt_req);

  // R7
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  // R7
  sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> !halt_req);

  // R9
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

endmodule

bind trace_recorder trace_recorder_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .store_fire(store_fire), .trig_fire(trig_fire),
  .trig_arm(trig_arm), .trig_halt_en(trig_halt_en), .frozen(frozen),
  .halt_req(halt_req), .sync_pulse(sync_pulse), .fill_count(fill_count),
  .rd_req(rd_req), .rd_valid(rd_valid)
);

// File: tb/trace_recorder_tb_top.sv
`timescale 1ns/1ps
module trace_recorder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [1:0]  bus_type = '0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic [3:0]  bus_ctrl = '0;
  logic [3:0]  type_enable = 4'hF;
  logic        trig_arm = 1'b0;
  logic        trig_halt_en = 1'b1;
  logic [15:0] trig_addr_val = '0, trig_addr_mask = '0;
  logic [7:0]  trig_data_val = '0, trig_data_mask = '0;
  logic [3:0]  trig_ctrl_val = '0, trig_ctrl_mask = '0;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_index = '0;
  logic [8:0]  fill_count;
  logic        frozen, halt_req, sync_pulse, rd_valid, rd_hit;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic [3:0]  rd_ctrl;
  logic [1:0]  rd_type;

  int tests = 0;
  int fails = 0;
  logic [29:0] model[$];

  always #2 clk = ~clk;

  trace_recorder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_type(bus_type),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
    .type_enable(type_enable), .trig_arm(trig_arm), .trig_halt_en(trig_halt_en),
    .trig_addr_val(trig_addr_val), .trig_addr_mask(trig_addr_mask),
    .trig_data_val(trig_data_val), .trig_data_mask(trig_data_mask),
    .trig_ctrl_val(trig_ctrl_val), .trig_ctrl_mask(trig_ctrl_mask),
    .rd_req(rd_req), .rd_index(rd_index), .fill_count(fill_count),
    .frozen(frozen), .halt_req(halt_req), .sync_pulse(sync_pulse),
    .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_ctrl(rd_ctrl), .rd_type(rd_type)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_fill();
    return (model.size() > 256) ? 256 : model.size();
  endfunction

  task automatic push(input logic [1:0] t, input logic [15:0] a,
                      input logic [7:0] d, input logic [3:0] c);
    model.push_back({t, c, d, a});
    if (model.size() > 256) void'(model.pop_front());
  endtask

  // One bus cycle; returns half a cycle after the edge that took it in.
  task automatic cyc(input logic [1:0] t, input logic [15:0] a,
                     input logic [7:0] d, input logic [3:0] c);
    @(negedge clk);
    bus_valid = 1'b1; bus_type = t; bus_addr = a; bus_data = d; bus_ctrl = c;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // Read index idx and compare against the model.
  task automatic rd_chk(input int idx, input string tag);
    logic [29:0] e;
    bit hit;
    @(negedge clk);
    rd_req = 1'b1; rd_index = 8'(idx);
    @(negedge clk);
    rd_req = 1'b0;
    hit = idx < exp_fill();
    chk({tag, " R9 rd_valid"}, 32'(rd_valid), 32'd1);
    chk({tag, " R4 rd_hit"}, 32'(rd_hit), 32'(hit));
    if (hit) begin
      e = model[model.size() - 1 - idx];
      chk({tag, " R1 entry"}, 32'({rd_type, rd_ctrl, rd_data, rd_addr}), 32'(e));
    end
  endtask

  task automatic t_reset();
    chk("R10 fill", 32'(fill_count), 32'd0);
    chk("R10 frozen", 32'(frozen), 32'd0);
    chk("R10 halt", 32'(halt_req), 32'd0);
    chk("R10 sync", 32'(sync_pulse), 32'd0);
    chk("R10 rd_valid", 32'(rd_valid), 32'd0);
    rd_chk(0, "R4 empty read");
  endtask

  task automatic t_basic();
    cyc(2'd1, 16'hBEEF, 8'h5A, 4'h9); push(2'd1, 16'hBEEF, 8'h5A, 4'h9);
    chk("R1 fill after one", 32'(fill_count), 32'd1);
    rd_chk(0, "R1 newest");
    rd_chk(1, "R4 beyond fill");
    cyc(2'd0, 16'h0102, 8'h33, 4'h1); push(2'd0, 16'h0102, 8'h33, 4'h1);
    rd_chk(1, "R9 index back");
    rd_chk(0, "R9 index zero");
  endtask

  task automatic t_filter();
    type_enable = 4'b1100;
    cyc(2'd0, 16'h1111, 8'h11, 4'h1);
    cyc(2'd1, 16'h2222, 8'h22, 4'h2);
    chk("R2 disabled types not counted", 32'(fill_count), 32'(exp_fill()));
    rd_chk(0, "R2 disabled types not stored");
    cyc(2'd3, 16'h4444, 8'h44, 4'h4); push(2'd3, 16'h4444, 8'h44, 4'h4);
    cyc(2'd2, 16'h3333, 8'h33, 4'h3); push(2'd2, 16'h3333, 8'h33, 4'h3);
    rd_chk(0, "R2 io read stored");
    rd_chk(1, "R2 io write stored");
    type_enable = 4'hF;
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 300; i++) begin
      cyc(2'(i), 16'h1000 + 16'(i), 8'(i * 3), 4'(i));
      push(2'(i), 16'h1000 + 16'(i), 8'(i * 3), 4'(i));
    end
    chk("R4 fill saturates", 32'(fill_count), 32'd256);
    rd_chk(255, "R3 oldest after wrap");
    rd_chk(128, "R3 middle after wrap");
    for (int k = 4; k >= 0; k--) rd_chk(k, "R3 last five oldest first");
    chk("R5 unarmed no freeze", 32'(frozen), 32'd0);
  endtask

  task automatic t_halt();
    trig_addr_val = 16'h12AB; trig_addr_mask = 16'hFF00;
    trig_data_mask = 8'h00; trig_ctrl_mask = 4'h0;
    trig_arm = 1'b0; trig_halt_en = 1'b1;
    cyc(2'd0, 16'h1255, 8'h01, 4'h0); push(2'd0, 16'h1255, 8'h01, 4'h0);
    chk("R5 disarmed match ignored", 32'(halt_req), 32'd0);
    trig_arm = 1'b1;
    cyc(2'd0, 16'h3456, 8'h02, 4'h0); push(2'd0, 16'h3456, 8'h02, 4'h0);
    chk("R5 mismatch no halt", 32'(halt_req), 32'd0);
    cyc(2'd1, 16'h12CD, 8'h77, 4'h5); push(2'd1, 16'h12CD, 8'h77, 4'h5);
    chk("R6 halt after trigger", 32'(halt_req), 32'd1);
    chk("R8 frozen after trigger", 32'(frozen), 32'd1);
    chk("R7 no sync in halt mode", 32'(sync_pulse), 32'd0);
    rd_chk(0, "R8 trigger cycle stored");
    cyc(2'd3, 16'h12AB, 8'h99, 4'h7);
    rd_chk(0, "R8 no store while frozen");
    chk("R6 halt held", 32'(halt_req), 32'd1);
    trig_arm = 1'b0;
    @(negedge clk);
    chk("R6 halt cleared by disarm", 32'(halt_req), 32'd0);
    chk("R8 freeze cleared by disarm", 32'(frozen), 32'd0);
    cyc(2'd2, 16'h0F0F, 8'hAA, 4'hC); push(2'd2, 16'h0F0F, 8'hAA, 4'hC);
    rd_chk(0, "R8 recording resumes");
  endtask

  task automatic t_sync();
    trig_addr_mask = 16'h0000; trig_ctrl_val = 4'hA; trig_ctrl_mask = 4'hF;
    trig_halt_en = 1'b0; trig_arm = 1'b1;
    cyc(2'd0, 16'h5555, 8'h10, 4'h3); push(2'd0, 16'h5555, 8'h10, 4'h3);
    chk("R5 ctrl mismatch", 32'(sync_pulse), 32'd0);
    cyc(2'd0, 16'h6666, 8'h20, 4'hA); push(2'd0, 16'h6666, 8'h20, 4'hA);
    chk("R7 sync pulse", 32'(sync_pulse), 32'd1);
    chk("R7 no halt in sync mode", 32'(halt_req), 32'd0);
    chk("R8 frozen in sync mode", 32'(frozen), 32'd1);
    @(negedge clk);
    chk("R7 sync one cycle", 32'(sync_pulse), 32'd0);
    cyc(2'd0, 16'h7777, 8'h30, 4'hA);
    chk("R8 no retrigger while frozen", 32'(sync_pulse), 32'd0);
    trig_arm = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disabled_trigger();
    type_enable = 4'b0001; trig_halt_en = 1'b1; trig_arm = 1'b1;
    cyc(2'd2, 16'h8888, 8'h40, 4'hA);
    chk("R8 trigger on disabled type", 32'(frozen), 32'd1);
    rd_chk(0, "R2 disabled trigger cycle not stored");
    trig_arm = 1'b0; type_enable = 4'hF;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_filter();
    t_wrap();
    t_halt();
    t_sync();
    t_disabled_trigger();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule